// File: doc/BRIEF.md
# BCD Calendar Clock Registers

This block holds a calendar clock as seven packed-BCD registers: seconds, minutes, hours (24-hour), day of week, date, month and two-digit year. Each register keeps its tens digit in the upper bits and its units digit in the low nibble. A one-cycle `tick_i` pulse, produced by a prescaler outside the block, advances the seconds. Each field that wraps carries into the next one, up through the year.

The seconds register also holds a halt flag. The hours register also holds a century-tracking enable and a century flag. The century flag flips on each 99-to-00 year wrap, but only while the enable is set. Date rollover follows the month length, and February has a leap day when the BCD year is a multiple of four.

A flat register port reads and writes the fields at addresses 0 to 6. Reads are combinational. A write to the seconds register sends a one-cycle pulse out, so that the external prescaler can restart its sub-second phase.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00, day 01, date 01, month 01 and year 00. The halt flag, century enable and century flag are all 0, and `subsec_clr_o` is 0.
- R2: Address map: 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month, 6 year. A write to an address stores the data, and a read returns it at once. Unused bit positions are dropped on write and read back as 0. The kept bit masks are 0xFF (seconds, halt in bit 7), 0x7F (minutes), 0xFF (hours: bit 7 enable, bit 6 century, bits 5:0 hours), 0x07 (day), 0x3F (date), 0x1F (month) and 0xFF (year). Address 7 reads 0, and a write to it changes nothing.
- R3: With the halt flag clear, each tick advances the seconds in BCD. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into both date and day.
- R4: While seconds bit 7 (halt) is 1, ticks are ignored and no field changes. Clearing the bit resumes counting from the held values.
- R5: Day of week advances at each date carry and wraps from 07 to 01.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Each date wrap advances the month, and month 12 wraps to 01 and advances the year.
- R7: February ends at 29 when the BCD year is a multiple of four (00 counts), and at 28 otherwise.
- R8: The year wraps 99 to 00. At that wrap, hours bit 6 inverts if hours bit 7 is 1 and holds if it is 0.
- R9: In a cycle with any write, a tick is dropped and no field advances from it.
- R10: `subsec_clr_o` is high for exactly one cycle, in the cycle after a write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| subsec_clr_o | output | 1 | Sub-second phase restart pulse |

## Verification
Carry chains are started from preset values one tick before a boundary. A lone seconds step tells the plain increment apart from the full cascade into minutes, hours, day, date, month and year. Month ends are tried in 30-day months, 31-day months and February, with years 23, 24, 00, 12 and 10, so that the leap rule is shown to depend on both BCD digits. Year wraps with the century enable set and clear separate flipping from holding. Ticks sent while halted, and ticks that coincide with writes, show that nothing moves in either case.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NF = 7;

  typedef logic [DW-1:0] byte_t;

  localparam logic [AW-1:0] A_SEC  = 3'd0;
  localparam logic [AW-1:0] A_MIN  = 3'd1;
  localparam logic [AW-1:0] A_HOUR = 3'd2;
  localparam logic [AW-1:0] A_DAY  = 3'd3;
  localparam logic [AW-1:0] A_DATE = 3'd4;
  localparam logic [AW-1:0] A_MON  = 3'd5;
  localparam logic [AW-1:0] A_YEAR = 3'd6;

  function automatic byte_t bcd_inc(byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four
  function automatic logic is_leap(byte_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic byte_t field_min(int i);
    return (i == 3 || i == 4 || i == 5) ? 8'h01 : 8'h00;
  endfunction

  // counter bits only; flags live elsewhere
  function automatic byte_t field_mask(int i);
    case (i)
      0, 1:    return 8'h7F;
      2:       return 8'h3F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter byte_t RST = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ld_i,
  input  byte_t ld_val_i,
  input  logic  inc_i,
  input  byte_t min_i,
  input  byte_t max_i,
  output byte_t val_o,
  output logic  wrap_o
);
  byte_t val_q;
  logic  at_top;

  assign at_top = (val_q >= max_i);
  assign wrap_o = inc_i && at_top;
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= RST;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= at_top ? min_i : bcd_inc(val_q);
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  byte_t month_i,
  input  byte_t year_i,
  output byte_t last_o
);
  always_comb begin
    case (month_i)
      8'h02:                      last_o = is_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_ctrl_bits.sv
module rtc_ctrl_bits (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_sec_i,
  input  logic       wr_hour_i,
  input  logic [1:0] wflags_i,
  input  logic       yr_wrap_i,
  output logic       stop_o,
  output logic       ceb_o,
  output logic       cb_o,
  output logic       subsec_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o       <= 1'b0;
      ceb_o        <= 1'b0;
      cb_o         <= 1'b0;
      subsec_clr_o <= 1'b0;
    end else begin
      subsec_clr_o <= wr_sec_i;
      if (wr_sec_i) stop_o <= wflags_i[1];
      if (wr_hour_i) begin
        ceb_o <= wflags_i[1];
        cb_o  <= wflags_i[0];
      end else if (yr_wrap_i && ceb_o) begin
        cb_o <= ~cb_o;
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
  import rtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          subsec_clr_o
);
  byte_t          fval [NF];
  byte_t          fmax [NF];
  logic  [NF-1:0] inc;
  logic  [NF-1:0] wrap;
  byte_t          last_date;
  logic           stop_q, ceb_q, cb_q;
  logic           unused_day_wrap;

  assign unused_day_wrap = wrap[3];

  rtc_month_len u_mlen (
    .month_i(fval[5]),
    .year_i (fval[6]),
    .last_o (last_date)
  );

  assign fmax[0] = 8'h59;
  assign fmax[1] = 8'h59;
  assign fmax[2] = 8'h23;
  assign fmax[3] = 8'h07;
  assign fmax[4] = last_date;
  assign fmax[5] = 8'h12;
  assign fmax[6] = 8'h99;

  // ripple carry; any write drops the tick
  assign inc[0] = tick_i && !stop_q && !wr_en_i;
  assign inc[1] = wrap[0];
  assign inc[2] = wrap[1];
  assign inc[3] = wrap[2];
  assign inc[4] = wrap[2];
  assign inc[5] = wrap[4];
  assign inc[6] = wrap[5];

  for (genvar g = 0; g < NF; g++) begin : g_field
    rtc_bcd_field #(.RST(field_min(g))) u_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_i    (wr_en_i && (addr_i == AW'(g))),
      .ld_val_i(wdata_i & field_mask(g)),
      .inc_i   (inc[g]),
      .min_i   (field_min(g)),
      .max_i   (fmax[g]),
      .val_o   (fval[g]),
      .wrap_o  (wrap[g])
    );
  end

  rtc_ctrl_bits u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_sec_i    (wr_en_i && (addr_i == A_SEC)),
    .wr_hour_i   (wr_en_i && (addr_i == A_HOUR)),
    .wflags_i    (wdata_i[7:6]),
    .yr_wrap_i   (wrap[6]),
    .stop_o      (stop_q),
    .ceb_o       (ceb_q),
    .cb_o        (cb_q),
    .subsec_clr_o(subsec_clr_o)
  );

  always_comb begin
    case (addr_i)
      A_SEC:   rdata_o = fval[0] | {stop_q, 7'd0};
      A_MIN:   rdata_o = fval[1];
      A_HOUR:  rdata_o = fval[2] | {ceb_q, cb_q, 6'd0};
      A_DAY:   rdata_o = fval[3];
      A_DATE:  rdata_o = fval[4];
      A_MON:   rdata_o = fval[5];
      A_YEAR:  rdata_o = fval[6];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_regs_chk.sv
module rtc_bcd_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       subsec_clr_o,
  input logic       stop_i,
  input logic       ceb_i,
  input logic       cb_i,
  input logic [7:0] sec_i,
  input logic [7:0] min_i,
  input logic [7:0] year_i
);
  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_en_i) |=> ($stable(sec_i) && $stable(min_i) && $stable(year_i))); // R4

  AST_SEC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sec_i) |-> $past(tick_i || wr_en_i)); // R3

  AST_CB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ceb_i && !(wr_en_i && addr_i == 3'd2)) |=> $stable(cb_i)); // R8

  AST_SUBSEC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0) |=> subsec_clr_o); // R10

  AST_ADDR7_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd7) |-> (rdata_o == 8'h00)); // R2

  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd1) |=> (min_i == ($past(wdata_i) & 8'h7F))); // R9
endmodule

bind rtc_bcd_regs rtc_bcd_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .subsec_clr_o(subsec_clr_o),
  .stop_i      (stop_q),
  .ceb_i       (ceb_q),
  .cb_i        (cb_q),
  .sec_i       (fval[0]),
  .min_i       (fval[1]),
  .year_i      (fval[6])
);

// File: tb/tb_rtc_bcd_regs.sv
`timescale 1ns/1ps
module tb_rtc_bcd_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       subsec_clr_o;
  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  rtc_bcd_regs dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rchk(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  // preload a date at 23:59:59
  task automatic preset(logic [7:0] yr, logic [7:0] mo, logic [7:0] dt, logic [7:0] dy, logic [7:0] hr);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dy);
    wr(3'd2, hr); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
  endtask

  task automatic t_reset();
    rchk("R1 sec", 3'd0, 8'h00); rchk("R1 min", 3'd1, 8'h00);
    rchk("R1 hour", 3'd2, 8'h00); rchk("R1 day", 3'd3, 8'h01);
    rchk("R1 date", 3'd4, 8'h01); rchk("R1 month", 3'd5, 8'h01);
    rchk("R1 year", 3'd6, 8'h00);
    chk("R1 subsec", {7'd0, subsec_clr_o}, 8'h00);
  endtask

  task automatic t_rw();
    wr(3'd0, 8'h45); rchk("R2 sec", 3'd0, 8'h45);
    wr(3'd1, 8'hFF); rchk("R2 min mask", 3'd1, 8'h7F);
    wr(3'd2, 8'hFF); rchk("R2 hour mask", 3'd2, 8'hFF);
    wr(3'd3, 8'hFF); rchk("R2 day mask", 3'd3, 8'h07);
    wr(3'd4, 8'hFF); rchk("R2 date mask", 3'd4, 8'h3F);
    wr(3'd5, 8'hFF); rchk("R2 month mask", 3'd5, 8'h1F);
    wr(3'd6, 8'h87); rchk("R2 year", 3'd6, 8'h87);
    wr(3'd7, 8'hA5); rchk("R2 addr7", 3'd7, 8'h00);
    rchk("R2 addr7 no side effect", 3'd6, 8'h87);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_ripple();
    preset(8'h23, 8'h12, 8'h31, 8'h07, 8'h23);
    wr(3'd0, 8'h58);
    tick(); rchk("R3 sec step", 3'd0, 8'h59); rchk("R3 min held", 3'd1, 8'h59);
    wr(3'd0, 8'h09);
    tick(); rchk("R3 bcd units carry", 3'd0, 8'h10);
    wr(3'd0, 8'h59);
    tick();
    rchk("R3 sec wrap", 3'd0, 8'h00); rchk("R3 min wrap", 3'd1, 8'h00);
    rchk("R3 hour wrap", 3'd2, 8'h00); rchk("R5 day wrap", 3'd3, 8'h01);
    rchk("R6 date wrap", 3'd4, 8'h01); rchk("R6 month wrap", 3'd5, 8'h01);
    rchk("R6 year step", 3'd6, 8'h24);
  endtask

  task automatic t_week();
    preset(8'h30, 8'h06, 8'h15, 8'h03, 8'h23);
    tick();
    rchk("R5 day step", 3'd3, 8'h04); rchk("R6 date step", 3'd4, 8'h16);
    rchk("R6 month held", 3'd5, 8'h06);
  endtask

  task automatic t_stop();
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h90);
    tick(); tick(); tick();
    rchk("R4 halted sec", 3'd0, 8'h90); rchk("R4 halted min", 3'd1, 8'h07);
    wr(3'd0, 8'h10);
    tick();
    rchk("R4 resume", 3'd0, 8'h11);
  endtask

  task automatic month_end(string req, logic [7:0] yr, logic [7:0] mo, logic [7:0] dt,
                           logic [7:0] exp_mo, logic [7:0] exp_dt);
    preset(yr, mo, dt, 8'h01, 8'h23);
    tick();
    rchk(req, 3'd5, exp_mo); rchk(req, 3'd4, exp_dt);
  endtask

  task automatic t_months();
    month_end("R6 30-day", 8'h23, 8'h04, 8'h30, 8'h05, 8'h01);
    month_end("R6 31-day", 8'h23, 8'h01, 8'h31, 8'h02, 8'h01);
    month_end("R6 31 in 30-day month no wrap at 30", 8'h23, 8'h07, 8'h30, 8'h07, 8'h31);
    month_end("R7 feb plain", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    month_end("R7 feb leap 24", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end("R7 feb leap 00", 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end("R7 feb leap 12", 8'h12, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end("R7 feb 10 plain", 8'h10, 8'h02, 8'h28, 8'h03, 8'h01);
    month_end("R7 feb 29 end", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
  endtask

  task automatic t_century();
    preset(8'h99, 8'h12, 8'h31, 8'h02, 8'hA3);
    tick();
    rchk("R8 year wrap", 3'd6, 8'h00); rchk("R8 century flips", 3'd2, 8'hC0);
    preset(8'h99, 8'h12, 8'h31, 8'h02, 8'h63);
    tick();
    rchk("R8 year wrap 2", 3'd6, 8'h00); rchk("R8 century held", 3'd2, 8'h40);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_priority();
    wr(3'd0, 8'h20);
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h05;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rchk("R9 tick dropped", 3'd0, 8'h20); rchk("R9 write taken", 3'd1, 8'h05);
  endtask

  task automatic t_subsec();
    wr(3'd0, 8'h30);
    chk("R10 pulse", {7'd0, subsec_clr_o}, 8'h01);
    @(negedge clk_i);
    chk("R10 one cycle", {7'd0, subsec_clr_o}, 8'h00);
    wr(3'd1, 8'h30);
    chk("R10 other addr", {7'd0, subsec_clr_o}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rw();
    t_ripple();
    t_week();
    t_stop();
    t_months();
    t_century();
    t_priority();
    t_subsec();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule